// File: doc/BRIEF.md
# Threshold Event Counter Bank

This block holds a set of event counters (eight by default, 32 bits each). Each counter owns four word registers on a small register bus: a command register, a threshold register, a count register and a status register. When a counter is running, it advances by one on every clock cycle in which its event input is high.

Each counter compares its count against its threshold through a three-bit relation mask. A true comparison sets a sticky status bit. If the counter's indicator enable is set, the comparison can also drive that counter's output pin and take part in a shared interrupt request. Each of those two outputs has its own enable bit. One write to command register 0 with the all-counters flag set loads the same command into every counter, so one bus access can start, stop or clear the whole bank.

Each counter runs a two-state machine. `ST_IDLE` holds the count, and a command write with the start opcode moves it to `ST_RUN`. `ST_RUN` counts events, and a command write with the stop opcode returns it to `ST_IDLE`. The hold and clear opcodes, and all undefined opcodes, leave the state unchanged.

Top module: `evc_bank`

## Requirements
- R1: After reset, every command, threshold, count and status register reads zero. All pins and the interrupt are low, and every counter is in `ST_IDLE`.
- R2: Byte address bits [6:4] select the counter and bits [3:2] select the register: 0 is command, 1 is threshold, 2 is count, 3 is status. An access with a nonzero address bits [1:0] is ignored. Read data appears on `bus_rdata` in the cycle after `bus_rd`. Threshold and count are read/write. A command register keeps bits 26:16 and reads zero in every other bit.
- R3: Command bits 19:16 are the opcode: 1 = start (`ST_IDLE` to `ST_RUN`), 2 = stop (`ST_RUN` to `ST_IDLE`), 0 and 4..15 = hold. In `ST_RUN` the count rises by one per cycle with the event input high. In `ST_IDLE` the count does not change.
- R4: Opcode 3 (clear) sets the count and the status bit to zero at the edge that writes the command.
- R5: Command bits 23:21 form the relation mask: bit 23 selects count < threshold, bit 22 selects equal, bit 21 selects greater than. The condition is true when any selected relation holds, so 000 is never true and 111 is always true.
- R6: Status bit 0 is set on every cycle in which the condition is true, whatever the enable bits are. It stays set until a read of the status register clears it. If the condition is true in the same cycle as that read, the bit stays set.
- R7: A counter's pin is high exactly while its condition is true, command bit 24 (indicator enable) is set and command bit 26 (pin enable) is set. The pin follows the live condition and does not use the status bit.
- R8: `irq` is high while any counter has its status bit set together with command bits 24 and 25 (interrupt enable).
- R9: A write to command register 0 with bit 20 set writes the same masked value into every command register, and every counter acts on that opcode at the same edge.
- R10: Bit 20 written to any other command register is stored but acts only on that counter.
- R11: A running count at 0xFFFFFFFF wraps to 0 on the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| ev_in | input | 8 | Per-counter event inputs |
| thr_pin | output | 8 | Per-counter live threshold pins |
| irq | output | 1 | Interrupt request from status bits |

## Verification
A write acts at the clock edge inside its cycle: counters, status and state change there, and pins and `irq` follow combinationally, so the bench samples them at the next falling edge. Read data is registered at the edge that sees `bus_rd` and is sampled at the falling edge after that edge. A status read-clear also shows on `irq` at that same sample. A burst of n event cycles always covers exactly n rising edges, because the bench drives the events only at falling edges. The expected counts therefore follow directly from n.

// File: rtl/evc_pkg.sv
package evc_pkg;
    localparam int BUS_W    = 32;
    localparam int B_PIN_EN = 26;
    localparam int B_IRQ_EN = 25;
    localparam int B_IND_EN = 24;
    localparam int B_REL_HI = 23;
    localparam int B_REL_LO = 21;
    localparam int B_ALL    = 20;
    localparam int B_OP_HI  = 19;
    localparam int B_OP_LO  = 16;
    localparam logic [BUS_W-1:0] CMD_KEEP = 32'h07FF_0000;

    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_e;

    typedef enum logic [3:0] {
        OP_HOLD  = 4'd0,
        OP_START = 4'd1,
        OP_STOP  = 4'd2,
        OP_CLEAR = 4'd3
    } opcode_e;

    typedef enum logic [1:0] {
        RS_CMD  = 2'd0,
        RS_THR  = 2'd1,
        RS_CNT  = 2'd2,
        RS_STAT = 2'd3
    } regsel_e;
endpackage

// File: rtl/evc_cmp.sv
module evc_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] count,
    input  logic [W-1:0] thresh,
    input  logic [2:0]   rel_mask,
    output logic         hit
);
    logic is_lt, is_eq, is_gt;

    always_comb begin
        is_lt = count < thresh;
        is_eq = count == thresh;
        is_gt = count > thresh;
        // mask order: [2]=less, [1]=equal, [0]=greater
        hit   = |(rel_mask & {is_lt, is_eq, is_gt});
    end
endmodule

// File: rtl/evc_regdec.sv
module evc_regdec
    import evc_pkg::*;
#(
    parameter int N_CNT = 8,
    localparam int GRP_W = (N_CNT > 1) ? $clog2(N_CNT) : 1,
    localparam int ADDR_W = GRP_W + 4
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              all_flag,
    output logic [N_CNT-1:0]  cmd_wr,
    output logic [N_CNT-1:0]  thr_wr,
    output logic [N_CNT-1:0]  cnt_wr,
    output logic [N_CNT-1:0]  stat_rd,
    output logic              rd_hit,
    output logic [GRP_W-1:0]  grp,
    output regsel_e           sel
);
    logic aligned, grp_ok, bcast;

    always_comb begin
        aligned = addr[1:0] == 2'b00;
        grp     = addr[ADDR_W-1:4];
        sel     = regsel_e'(addr[3:2]);
        grp_ok  = int'(grp) < N_CNT;
        rd_hit  = aligned && grp_ok;
        bcast   = wr_en && aligned && (grp == '0) && (sel == RS_CMD) && all_flag;
    end

    for (genvar i = 0; i < N_CNT; i++) begin : g_dec
        logic mine;
        always_comb begin
            mine       = aligned && (grp == GRP_W'(i));
            cmd_wr[i]  = (wr_en && mine && (sel == RS_CMD)) || bcast;
            thr_wr[i]  = wr_en && mine && (sel == RS_THR);
            cnt_wr[i]  = wr_en && mine && (sel == RS_CNT);
            stat_rd[i] = rd_en && mine && (sel == RS_STAT);
        end
    end
endmodule

// File: rtl/evc_counter.sv
module evc_counter
    import evc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic             thr_wr,
    input  logic             cnt_wr,
    input  logic             stat_rd,
    input  logic [BUS_W-1:0] wdata,
    input  logic             ev,
    output logic [BUS_W-1:0] cmd_q,
    output logic [CNT_W-1:0] thr_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             stat_q,
    output logic             pin,
    output logic             irq_req
);
    run_state_e state_q, state_d;
    logic [3:0] op;
    logic       running, hit, do_clear;

    assign op       = wdata[B_OP_HI:B_OP_LO];
    assign do_clear = cmd_wr && (op == OP_CLEAR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_wr && op == OP_START) state_d = ST_RUN;
            ST_RUN:  if (cmd_wr && op == OP_STOP)  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        running = state_q == ST_RUN;
        pin     = hit && cmd_q[B_IND_EN] && cmd_q[B_PIN_EN];
        irq_req = stat_q && cmd_q[B_IND_EN] && cmd_q[B_IRQ_EN];
    end

    evc_cmp #(.W(CNT_W)) u_cmp (
        .count   (cnt_q),
        .thresh  (thr_q),
        .rel_mask(cmd_q[B_REL_HI:B_REL_LO]),
        .hit     (hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            thr_q  <= '0;
            cnt_q  <= '0;
            stat_q <= 1'b0;
        end else begin
            if (cmd_wr) cmd_q <= wdata & CMD_KEEP;
            if (thr_wr) thr_q <= wdata[CNT_W-1:0];
            if (do_clear)            cnt_q <= '0;
            else if (cnt_wr)         cnt_q <= wdata[CNT_W-1:0];
            else if (running && ev)  cnt_q <= cnt_q + CNT_W'(1);
            if (do_clear)            stat_q <= 1'b0;
            else if (hit)            stat_q <= 1'b1;
            else if (stat_rd)        stat_q <= 1'b0;
        end
    end

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ev && !cmd_wr && !cnt_wr) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
    assert_idle_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cmd_wr && !cnt_wr) |=> $stable(cnt_q));
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        do_clear |=> (cnt_q == '0) && !stat_q);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !do_clear && (!stat_rd || hit)) |=> stat_q);
endmodule

// File: rtl/evc_bank.sv
module evc_bank
    import evc_pkg::*;
#(
    parameter int N_CNT = 8,
    parameter int CNT_W = 32,
    localparam int GRP_W = (N_CNT > 1) ? $clog2(N_CNT) : 1,
    localparam int ADDR_W = GRP_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [N_CNT-1:0]  ev_in,
    output logic [N_CNT-1:0]  thr_pin,
    output logic              irq
);
    logic [N_CNT-1:0] cmd_wr, thr_wr, cnt_wr, stat_rd, stat_v, irq_v;
    logic             rd_hit;
    logic [GRP_W-1:0] grp;
    regsel_e          sel;
    logic [BUS_W-1:0] cmd_q [N_CNT];
    logic [CNT_W-1:0] thr_q [N_CNT];
    logic [CNT_W-1:0] cnt_q [N_CNT];
    logic [BUS_W-1:0] rd_word;

    evc_regdec #(.N_CNT(N_CNT)) u_dec (
        .wr_en   (bus_wr),
        .rd_en   (bus_rd),
        .addr    (bus_addr),
        .all_flag(bus_wdata[B_ALL]),
        .cmd_wr  (cmd_wr),
        .thr_wr  (thr_wr),
        .cnt_wr  (cnt_wr),
        .stat_rd (stat_rd),
        .rd_hit  (rd_hit),
        .grp     (grp),
        .sel     (sel)
    );

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        evc_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd_wr (cmd_wr[i]),
            .thr_wr (thr_wr[i]),
            .cnt_wr (cnt_wr[i]),
            .stat_rd(stat_rd[i]),
            .wdata  (bus_wdata),
            .ev     (ev_in[i]),
            .cmd_q  (cmd_q[i]),
            .thr_q  (thr_q[i]),
            .cnt_q  (cnt_q[i]),
            .stat_q (stat_v[i]),
            .pin    (thr_pin[i]),
            .irq_req(irq_v[i])
        );

        assert_bcast_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == '0 && bus_wdata[B_ALL])
            |=> cmd_q[i] == ($past(bus_wdata) & CMD_KEEP));
        assert_pin_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
            thr_pin[i] |-> (cmd_q[i][B_IND_EN] && cmd_q[i][B_PIN_EN]));
    end

    assign irq = |irq_v;

    always_comb begin
        rd_word = '0;
        if (rd_hit) begin
            unique case (sel)
                RS_CMD:  rd_word = cmd_q[grp];
                RS_THR:  rd_word = BUS_W'(thr_q[grp]);
                RS_CNT:  rd_word = BUS_W'(cnt_q[grp]);
                RS_STAT: rd_word = BUS_W'(stat_v[grp]);
                default: rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

    assert_irq_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_v != '0));
    assert_local_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[1:0] == 2'b00 && bus_addr[3:2] == 2'b00
         && bus_addr[ADDR_W-1:4] != '0) |-> $onehot0(cmd_wr));
endmodule

// File: tb/sim_evc_bank.sv
module sim_evc_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  ev_in = '0;
    logic [7:0]  thr_pin;
    logic        irq;
    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    localparam logic [31:0] PIN = 32'h0400_0000, IRQ = 32'h0200_0000,
                            IND = 32'h0100_0000, ALL = 32'h0010_0000;
    localparam logic [31:0] START = 32'h0001_0000, STOP = 32'h0002_0000,
                            CLR = 32'h0003_0000;

    always #5 clk = ~clk;

    evc_bank u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
                 .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
                 .ev_in(ev_in), .thr_pin(thr_pin), .irq(irq));

    function automatic logic [6:0] ra(int g, int s);
        return {g[2:0], s[1:0], 2'b00};
    endfunction

    function automatic logic [31:0] rel(int cc);
        return {8'h0, cc[2:0], 21'h0};
    endfunction

    function automatic bit cond_exp(logic [31:0] c, logic [31:0] t, int cc);
        return (cc[2] && c < t) || (cc[1] && c == t) || (cc[0] && c > t);
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(logic [6:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic events(logic [7:0] m, int n);
        @(negedge clk); ev_in = m;
        repeat (n) @(negedge clk);
        ev_in = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int g = 0; g < 8; g += 7) begin
            for (int s = 0; s < 4; s++) begin
                rd(ra(g, s), d); chk("R1 reset reg", d, 0);
            end
        end
        chk("R1 pins", {24'h0, thr_pin}, 0);
        chk("R1 irq", {31'h0, irq}, 0);
    endtask

    task automatic t_count();
        logic [31:0] d;
        wr(ra(1, 0), START);
        events(8'h06, 7);
        wr(ra(1, 0), STOP);
        rd(ra(1, 2), d); chk("R3 count run", d, 7);
        rd(ra(2, 2), d); chk("R3 idle no count", d, 0);
        events(8'h02, 4);
        rd(ra(1, 2), d); chk("R3 stopped", d, 7);
        wr(ra(1, 0), 32'h0009_0000);
        events(8'h02, 2);
        rd(ra(1, 2), d); chk("R3 undefined op holds", d, 7);
        wr(ra(1, 1), 32'h0000_1234);
        rd(ra(1, 1), d); chk("R2 threshold rw", d, 32'h1234);
        wr(ra(1, 1) | 7'd2, 32'h0000_5555);
        rd(ra(1, 1), d); chk("R2 misaligned ignored", d, 32'h1234);
    endtask

    task automatic t_compare();
        int thr [3] = '{5, 7, 9};
        foreach (thr[k]) begin
            wr(ra(1, 1), thr[k]);
            for (int cc = 0; cc < 8; cc++) begin
                wr(ra(1, 0), PIN | IND | rel(cc));
                chk($sformatf("R5 R7 pin thr=%0d cc=%0d", thr[k], cc),
                    {31'h0, thr_pin[1]}, {31'h0, cond_exp(7, thr[k], cc)});
            end
        end
    endtask

    task automatic t_status();
        logic [31:0] d;
        wr(ra(1, 0), rel(0));
        rd(ra(1, 3), d); chk("R6 sticky", d, 1);
        rd(ra(1, 3), d); chk("R6 read clears", d, 0);
        wr(ra(1, 0), PIN | IRQ | rel(7));
        @(negedge clk);
        chk("R7 pin needs indicator", {31'h0, thr_pin[1]}, 0);
        chk("R8 irq needs indicator", {31'h0, irq}, 0);
        rd(ra(1, 3), d); chk("R6 set without indicator", d, 1);
        wr(ra(1, 0), PIN | IRQ | IND | rel(7));
        @(negedge clk);
        chk("R7 pin on", {31'h0, thr_pin[1]}, 1);
        chk("R8 irq on", {31'h0, irq}, 1);
        rd(ra(1, 3), d); chk("R6 read", d, 1);
        rd(ra(1, 3), d); chk("R6 set wins over clear", d, 1);
        wr(ra(1, 0), PIN | IRQ | IND | rel(0));
        chk("R7 pin follows live", {31'h0, thr_pin[1]}, 0);
        chk("R8 irq from sticky", {31'h0, irq}, 1);
        rd(ra(1, 3), d);
        chk("R8 irq drops after clear", {31'h0, irq}, 0);
        wr(ra(1, 0), IRQ | IND | rel(7));
        wr(ra(1, 0), IRQ | IND | rel(0));
        chk("R8 irq before local clear", {31'h0, irq}, 1);
        wr(ra(1, 0), CLR);
        chk("R4 irq after clear", {31'h0, irq}, 0);
        rd(ra(1, 2), d); chk("R4 count cleared", d, 0);
        rd(ra(1, 3), d); chk("R4 status cleared", d, 0);
    endtask

    task automatic t_broadcast();
        logic [31:0] d;
        wr(ra(0, 0), ALL | START);
        events(8'hFF, 4);
        wr(ra(0, 0), ALL | STOP);
        for (int g = 0; g < 8; g++) begin
            rd(ra(g, 2), d); chk($sformatf("R9 count %0d", g), d, 4);
        end
        rd(ra(5, 0), d); chk("R9 copy", d, ALL | STOP);
        wr(ra(0, 0), ALL | CLR);
        rd(ra(6, 2), d); chk("R9 bcast clear", d, 0);
        wr(ra(3, 0), ALL | START);
        events(8'hFF, 3);
        wr(ra(3, 0), STOP);
        rd(ra(3, 2), d); chk("R10 local count", d, 3);
        rd(ra(0, 2), d); chk("R10 c0 untouched", d, 0);
        rd(ra(5, 2), d); chk("R10 c5 untouched", d, 0);
        rd(ra(0, 0), d); chk("R10 cmd0 untouched", d, ALL | CLR);
        wr(ra(2, 0), 32'hFFFF_FFFF);
        rd(ra(2, 0), d); chk("R2 reserved zero", d, 32'h07FF_0000);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        wr(ra(4, 2), 32'hFFFF_FFFE);
        rd(ra(4, 2), d); chk("R2 count rw", d, 32'hFFFF_FFFE);
        wr(ra(4, 0), START);
        events(8'h10, 3);
        wr(ra(4, 0), STOP);
        rd(ra(4, 2), d); chk("R11 wrap", d, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_compare();
        t_status();
        t_broadcast();
        t_wrap();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog R1..R11 got=timeout exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule